// File: doc/BRIEF.md
# Counter Carry-Chain Self-Test Sequencer

This block runs a fixed, deterministic self-test on a loadable up/down binary counter of parameter width W, which is part of the block as the circuit under test. A start pulse launches the test. The sequencer then takes over the counter's load, load value, enable and direction controls and steps it through a short script. The script exercises the longest carry path, the longest borrow path, and a sweep in which every bit goes through both directions of change.

A behavioural predictor runs beside the counter. One cycle after each step it holds the value the counter should show. Any disagreement raises a sticky failure flag. When the script ends, the counter is loaded back to zero and a done flag rises. A stuck-at-0 fault can be forced onto any chosen counter bit, which proves that the comparison catches real defects. The controls and the counter value are visible at the ports.

Top module: `cnt_selftest`

## Requirements
- R1: After reset, done and fail are 0 and the counter value is 0.
- R2: The first step loads 2^(W-1)-1 (the MSB clear, all lower bits set), and this value appears on cut_q one cycle after the start pulse is sampled.
- R3: The second step increments once, so cut_q shows 2^(W-1) and the carry has rippled through every lower bit.
- R4: The third step decrements once, so cut_q shows 2^(W-1)-1 again, which drives the borrow down the full chain.
- R5: For each bit i in ascending order there are four steps: load all ones except bit i, hold, load only bit i, hold. Each value can be seen on cut_q one cycle after its step.
- R6: The script has 4W+3 steps. done stays 0 while it runs and becomes 1 one cycle after the last comparison, which is W*4+4 cycles after the start pulse is sampled.
- R7: When done rises, the counter has been loaded back to 0.
- R8: Any mismatch between cut_q and the predicted value sets fail, and fail holds until the next accepted start. With fault_en=1, bit fault_sel of the counter is stuck at 0, and fail must be 1 when done rises.
- R9: An accepted start clears done and fail in the next cycle.
- R10: A start pulse while the script is running is ignored, and the run finishes at its original time.
- R11: After the run, done stays 1 and the counter holds 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start the self-test when idle or finished |
| fault_en | input | 1 | Force a stuck-at-0 fault on one counter bit |
| fault_sel | input | SELW | Index of the faulted bit |
| done | output | 1 | Test complete |
| fail | output | 1 | Sticky mismatch flag |
| cut_load | output | 1 | Counter load control |
| cut_en | output | 1 | Counter count enable |
| cut_up | output | 1 | Counter direction, 1 = up |
| cut_val | output | W | Counter load value |
| cut_q | output | W | Counter value as observed |

## Verification
The hardest case to reach from the ports is a stuck bit that only the carry step can expose: a fault on the MSB is invisible until the increment from 2^(W-1)-1. Bits that the first load sets fail earlier. The bench runs faulted tests with the stuck bit on the LSB, a middle bit and the MSB, and checks that each one ends with fail raised. It also pulses start partway through a clean run, which shows that the completion time and the value sequence stay as they were.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_UP   = 2'd2,
    OP_DOWN = 2'd3
  } cst_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } cst_state_e;
endpackage

// File: rtl/cst_counter.sv
module cst_counter #(
  parameter int W    = 8,
  parameter int SELW = (W > 1) ? $clog2(W) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [W-1:0]    load_val,
  input  logic            en,
  input  logic            up,
  input  logic            flt_en,
  input  logic [SELW-1:0] flt_sel,
  output logic [W-1:0]    q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic [W-1:0] flt_mask;
  logic [W-1:0] q_obs;

  // stuck-at-0 injection sits on the register output, so the fault also feeds the arithmetic
  always_comb begin
    flt_mask = flt_en ? (W'(1) << flt_sel) : '0;
    q_obs    = q_r & ~flt_mask;
  end

  always_comb begin
    q_nxt = q_obs;
    if (load)        q_nxt = load_val;
    else if (en) begin
      if (up)        q_nxt = q_obs + W'(1);
      else           q_nxt = q_obs - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q_r <= '0;
    else if (load || en)   q_r <= q_nxt;
  end

  assign q = q_obs;

  // R2: a load lands in the register on the next edge
  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q_r == $past(load_val)));

  // R11: with no load and no enable the stored value does not move
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en && !flt_en) |=> $stable(q_r));
endmodule

// File: rtl/cst_pattern.sv
module cst_pattern
  import cst_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = $clog2(4 * W + 3)
) (
  input  logic [SW-1:0] step,
  output cst_op_e       op,
  output logic [W-1:0]  val
);
  localparam logic [W-1:0] MID_VAL = {1'b0, {(W-1){1'b1}}};

  logic [SW-1:0] rel;
  logic [W-1:0]  bit_hot;

  always_comb begin
    rel     = step - SW'(3);
    bit_hot = W'(1) << rel[SW-1:2];
  end

  always_comb begin
    op  = OP_HOLD;
    val = '0;
    if (step == SW'(0)) begin
      op  = OP_LOAD;
      val = MID_VAL;
    end else if (step == SW'(1)) begin
      op  = OP_UP;
    end else if (step == SW'(2)) begin
      op  = OP_DOWN;
    end else begin
      unique case (rel[1:0])
        2'd0: begin op = OP_LOAD; val = ~bit_hot; end
        2'd1: op = OP_HOLD;
        2'd2: begin op = OP_LOAD; val = bit_hot; end
        default: op = OP_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/cst_seq.sv
module cst_seq
  import cst_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = $clog2(4 * W + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  cst_op_e       op,
  input  logic [W-1:0]  pat_val,
  input  logic [W-1:0]  cut_q,
  output logic [SW-1:0] step,
  output logic          ctl_load,
  output logic          ctl_en,
  output logic          ctl_up,
  output logic [W-1:0]  ctl_val,
  output logic          done,
  output logic          fail
);
  localparam int LAST = 4 * W + 2;

  cst_state_e    state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic [W-1:0]  pred_q, pred_d;
  logic          cmp_q, cmp_d;
  logic          fail_q, fail_d;
  logic          done_q, done_d;
  logic          accept;
  logic          mismatch;

  always_comb begin
    accept   = start && (state_q == ST_IDLE || state_q == ST_DONE);
    mismatch = cmp_q && (cut_q != pred_q);
  end

  // controls presented to the counter
  always_comb begin
    ctl_load = 1'b0;
    ctl_en   = 1'b0;
    ctl_up   = 1'b0;
    ctl_val  = '0;
    if (state_q == ST_RUN) begin
      ctl_load = (op == OP_LOAD);
      ctl_en   = (op == OP_UP) || (op == OP_DOWN);
      ctl_up   = (op == OP_UP);
      ctl_val  = pat_val;
    end else if (state_q == ST_DRAIN) begin
      ctl_load = 1'b1;
    end
  end

  // next state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    pred_d  = pred_q;
    cmp_d   = (state_q == ST_RUN);
    fail_d  = fail_q | mismatch;
    done_d  = done_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          state_d = ST_RUN;
          step_d  = '0;
          fail_d  = 1'b0;
          done_d  = 1'b0;
        end
      end
      ST_RUN: begin
        unique case (op)
          OP_LOAD: pred_d = pat_val;
          OP_UP:   pred_d = pred_q + W'(1);
          OP_DOWN: pred_d = pred_q - W'(1);
          default: pred_d = pred_q;
        endcase
        if (step_q == SW'(LAST)) state_d = ST_DRAIN;
        else                     step_d  = step_q + SW'(1);
      end
      default: begin
        state_d = ST_DONE;
        done_d  = 1'b1;
        pred_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      pred_q  <= '0;
      cmp_q   <= 1'b0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      pred_q  <= pred_d;
      cmp_q   <= cmp_d;
      fail_q  <= fail_d;
      done_q  <= done_d;
    end
  end

  assign step = step_q;
  assign done = done_q;
  assign fail = fail_q;

  // R8: fail only drops through an accepted start
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !accept) |=> fail_q);

  // R9: an accepted start clears both flags
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!done_q && !fail_q));

  // R6: done stays low while steps are being issued
  a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> !done_q);

  // R10: start during a run does not restart the step count
  a_r10_run_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && step_q != SW'(LAST)) |=> (step_q == $past(step_q) + SW'(1)));
endmodule

// File: rtl/cnt_selftest.sv
module cnt_selftest
  import cst_pkg::*;
#(
  parameter int W = 8,
  localparam int SELW = (W > 1) ? $clog2(W) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            fault_en,
  input  logic [SELW-1:0] fault_sel,
  output logic            done,
  output logic            fail,
  output logic            cut_load,
  output logic            cut_en,
  output logic            cut_up,
  output logic [W-1:0]    cut_val,
  output logic [W-1:0]    cut_q
);
  localparam int SW = $clog2(4 * W + 3);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [SW-1:0] step;
  cst_op_e       op;
  logic [W-1:0]  pat_val;

  cst_pattern #(.W(W), .SW(SW)) u_pat (
    .step (step),
    .op   (op),
    .val  (pat_val)
  );

  cst_seq #(.W(W), .SW(SW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .op       (op),
    .pat_val  (pat_val),
    .cut_q    (cut_q),
    .step     (step),
    .ctl_load (cut_load),
    .ctl_en   (cut_en),
    .ctl_up   (cut_up),
    .ctl_val  (cut_val),
    .done     (done),
    .fail     (fail)
  );

  cst_counter #(.W(W), .SELW(SELW)) u_cut (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cut_load),
    .load_val (cut_val),
    .en       (cut_en),
    .up       (cut_up),
    .flt_en   (fault_en),
    .flt_sel  (fault_sel),
    .q        (cut_q)
  );

  // R7: the counter is back at zero when done rises (fault-free)
  a_r7_restored: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(done) && !fault_en) |-> (cut_q == '0));
endmodule

// File: tb/cnt_selftest_test.sv
`timescale 1ns/1ps
module cnt_selftest_test;
  localparam int W    = 8;
  localparam int SELW = $clog2(W);
  localparam int S    = 4 * W + 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic            fault_en;
  logic [SELW-1:0] fault_sel;
  logic            done, fail, cut_load, cut_en, cut_up;
  logic [W-1:0]    cut_val, cut_q;

  int nchk  = 0;
  int nfail = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  cnt_selftest #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_en(fault_en),
    .fault_sel(fault_sel), .done(done), .fail(fail), .cut_load(cut_load),
    .cut_en(cut_en), .cut_up(cut_up), .cut_val(cut_val), .cut_q(cut_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural model of the expected value after each step
  task automatic build_model();
    int mask = (1 << W) - 1;
    int mid  = (1 << (W - 1)) - 1;
    exp_q.delete();
    exp_q.push_back(mid);
    exp_q.push_back(mid + 1);
    exp_q.push_back(mid);
    for (int i = 0; i < W; i++) begin
      exp_q.push_back(~(1 << i) & mask);
      exp_q.push_back(~(1 << i) & mask);
      exp_q.push_back(1 << i);
      exp_q.push_back(1 << i);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_clean(input bit poke);
    pulse_start();
    for (int j = 1; j <= S + 1; j++) begin
      @(negedge clk);
      start = 1'b0;
      if (j == 1) begin
        chk("R9 fail cleared", int'(fail), 0);
        chk("R9 done cleared", int'(done), 0);
      end
      if (j <= S) begin
        if (j == 1)      chk("R2 preload", int'(cut_q), exp_q[0]);
        else if (j == 2) chk("R3 carry", int'(cut_q), exp_q[1]);
        else if (j == 3) chk("R4 borrow", int'(cut_q), exp_q[2]);
        else             chk(poke ? "R10 sweep" : "R5 sweep", int'(cut_q), exp_q[j-1]);
        chk("R6 done low", int'(done), 0);
      end else begin
        chk("R6 done", int'(done), 1);
        chk("R7 restored", int'(cut_q), 0);
        chk("R8 clean fail", int'(fail), 0);
      end
      if (poke && j == 10) start = 1'b1;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 done held", int'(done), 1);
      chk("R11 value held", int'(cut_q), 0);
    end
  endtask

  task automatic run_fault(input int sel);
    fault_en  = 1'b1;
    fault_sel = SELW'(sel);
    pulse_start();
    for (int j = 1; j <= S + 1; j++) @(negedge clk);
    chk("R8 fault done", int'(done), 1);
    chk("R8 fault fail", int'(fail), 1);
    @(negedge clk);
    chk("R8 fail sticky", int'(fail), 1);
    fault_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    start     = 1'b0;
    fault_en  = 1'b0;
    fault_sel = '0;
    build_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail), 0);
    chk("R1 value", int'(cut_q), 0);

    run_clean(1'b0);
    run_fault(0);
    run_clean(1'b0);
    run_fault(W / 2);
    run_fault(W - 1);
    run_clean(1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule